// File: doc/BRIEF.md
# Three-Phase Hysteresis Current Comparator

This block closes a bang-bang current loop around the three legs of a bridge inverter. Each cycle it takes a signed reference current and a signed measured current per phase, plus one shared unsigned half-band. From these it forms an upper limit and a lower limit around each reference. A per-leg state register then decides which switch of the leg conducts. Above the window the lower switch conducts and pulls the current down. Below the window the upper switch conducts and pushes it up. Inside the window the leg keeps its last decision.

A minimum-dwell counter on every leg keeps the leg from changing state again until a set number of clocks has passed since its last change. This bounds the switching rate of the power devices. A single enable input turns off both switches of every leg. Two registered band-violation flags per phase report where the measured current sits relative to its window. Dead-time insertion, sensing and reference shaping sit outside this block.

Top module: `hcc_three_phase`

## Requirements
- R1: The limits are formed one bit wider than the current inputs: upper = reference + half-band, lower = reference - half-band. A reference near either end of the signed range never wraps into a false crossing.
- R2: `over_band[p]` registers (measured >= upper) and `under_band[p]` registers (measured <= lower) at each clock edge. This holds whatever the enable and gate state are.
- R3: When enabled, a measured current at or above the upper limit turns `gate_lo[p]` on and `gate_hi[p]` off at the next edge, if the dwell time allows it.
- R4: When enabled, a measured current at or below the lower limit, and not also at or above the upper limit, turns `gate_hi[p]` on and `gate_lo[p]` off at the next edge, if the dwell time allows it.
- R5: While the measured current lies strictly between the limits, both gates of that leg keep their values.
- R6: `gate_hi[p]` and `gate_lo[p]` are never high together.
- R7: With `en` low at an edge, both gates of every leg are low after that edge. The dwell timer is cleared, so the first crossing after re-enable acts at once.
- R8: After reset, all gates and flags are low. Each leg keeps both gates off until its first band crossing.
- R9: After a leg changes from one conducting switch to the other, it makes no further such change for `DWELL_CLKS` edges. A crossing that is still present takes effect exactly `DWELL_CLKS` edges after the previous change.
- R10: Phase p uses bits [p*CUR_W +: CUR_W] of the current vectors and bit p of the gate and flag vectors. The pairs (gate_hi[p], gate_lo[p]) are switches 1/2, 3/4 and 5/6 for p = 0, 1, 2. The phases act independently.
- R11: With a zero half-band, a measured current equal to the reference raises both flags, and the above-limit decision (lower switch on) takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Leg enable; low forces all gates off |
| half_band | input | HB_W | Unsigned half width of the tolerance window |
| ref_cur | input | 3*CUR_W | Signed reference currents, phase p at [p*CUR_W +: CUR_W] |
| meas_cur | input | 3*CUR_W | Signed measured currents, same packing |
| gate_hi | output | 3 | Upper switch drive per leg (switches 1, 3, 5) |
| gate_lo | output | 3 | Lower switch drive per leg (switches 2, 4, 6) |
| over_band | output | 3 | Registered flag: measured at or above upper limit |
| under_band | output | 3 | Registered flag: measured at or below lower limit |

## Verification
The properties assume that every input settles between clock edges. The flag-exclusion property applies only while the half-band is non-zero, because a zero window lets both comparisons hold at once. The above-limit action property does not depend on that assumption, since that decision has priority. The stimulus changes inputs only on the falling edge. It keeps the sinusoidal reference plus ripple well inside the signed range, and it uses a zero half-band in only one deliberate segment.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
   localparam int NUM_LEGS = 3;

   typedef enum logic [1:0] {
      LEG_OFF = 2'b00,
      LEG_HI  = 2'b01,
      LEG_LO  = 2'b10
   } leg_state_e;
endpackage

// File: rtl/hcc_band_cmp.sv
module hcc_band_cmp #(
   parameter int CUR_W = 12,
   parameter int HB_W  = 8
) (
   input  logic signed [CUR_W-1:0] ref_i,
   input  logic signed [CUR_W-1:0] meas_i,
   input  logic        [HB_W-1:0]  hb_i,
   output logic                    at_upper_o,
   output logic                    at_lower_o
);
   // one guard bit keeps ref +/- half-band from wrapping
   localparam int EW = CUR_W + 1;

   if (HB_W >= CUR_W) begin : g_bad_width
      $error("hcc_band_cmp: HB_W must be below CUR_W");
   end

   logic signed [EW-1:0] ref_x, meas_x, hb_x, lim_up, lim_dn;

   always_comb begin
      ref_x  = EW'(ref_i);
      meas_x = EW'(meas_i);
      hb_x   = $signed({{(EW-HB_W){1'b0}}, hb_i});
      lim_up = ref_x + hb_x;
      lim_dn = ref_x - hb_x;
   end

   assign at_upper_o = (meas_x >= lim_up);
   assign at_lower_o = (meas_x <= lim_dn);
endmodule

// File: rtl/hcc_leg.sv
module hcc_leg
   import hcc_pkg::*;
#(
   parameter int DWELL_CLKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic over_i,
   input  logic under_i,
   output logic gate_hi_o,
   output logic gate_lo_o
);
   localparam int CW = (DWELL_CLKS > 1) ? $clog2(DWELL_CLKS) : 1;
   localparam int AW = $clog2(DWELL_CLKS + 1);

   if (DWELL_CLKS < 1) begin : g_bad_dwell
      $error("hcc_leg: DWELL_CLKS must be at least 1");
   end

   leg_state_e st_q, st_d;
   logic       dwell_ok;

   always_comb begin
      st_d = st_q;
      if (!en)
         st_d = LEG_OFF;
      else if (over_i && st_q != LEG_LO && dwell_ok)
         st_d = LEG_LO;
      else if (!over_i && under_i && st_q != LEG_HI && dwell_ok)
         st_d = LEG_HI;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LEG_OFF;
      else        st_q <= st_d;
   end

   if (DWELL_CLKS > 1) begin : g_dwell
      logic [CW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              hold_q <= '0;
         else if (!en)            hold_q <= '0;
         else if (st_d != st_q)   hold_q <= CW'(DWELL_CLKS - 1);
         else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      end
      assign dwell_ok = (hold_q == '0);
   end else begin : g_no_dwell
      assign dwell_ok = 1'b1;
   end

   assign gate_hi_o = (st_q == LEG_HI);
   assign gate_lo_o = (st_q == LEG_LO);

   // observer: edges since the last change seen on the gate pins
   logic [1:0]    prev_q;
   logic [AW-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 2'b00;
         age_q  <= AW'(DWELL_CLKS);
      end else begin
         prev_q <= {gate_hi_o, gate_lo_o};
         if ({gate_hi_o, gate_lo_o} != prev_q)  age_q <= AW'(1);
         else if (age_q < AW'(DWELL_CLKS))      age_q <= age_q + 1'b1;
      end
   end

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o && gate_lo_o)); // R6
   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!gate_hi_o && !gate_lo_o)); // R7
   AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !over_i && !under_i) |=> ($stable(gate_hi_o) && $stable(gate_lo_o))); // R5
   AST_OVER_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && over_i && dwell_ok) |=> (gate_lo_o && !gate_hi_o)); // R3
   AST_UNDER_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && under_i && !over_i && dwell_ok) |=> (gate_hi_o && !gate_lo_o)); // R4
   AST_DWELL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (({gate_hi_o, gate_lo_o} != prev_q) && prev_q != 2'b00 &&
       {gate_hi_o, gate_lo_o} != 2'b00) |-> (age_q == AW'(DWELL_CLKS))); // R9
endmodule

// File: rtl/hcc_three_phase.sv
module hcc_three_phase
   import hcc_pkg::*;
#(
   parameter int CUR_W      = 12,
   parameter int HB_W       = 8,
   parameter int DWELL_CLKS = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [HB_W-1:0]           half_band,
   input  logic [NUM_LEGS*CUR_W-1:0] ref_cur,
   input  logic [NUM_LEGS*CUR_W-1:0] meas_cur,
   output logic [NUM_LEGS-1:0]       gate_hi,
   output logic [NUM_LEGS-1:0]       gate_lo,
   output logic [NUM_LEGS-1:0]       over_band,
   output logic [NUM_LEGS-1:0]       under_band
);
   if (CUR_W < 2) begin : g_bad_cur
      $error("hcc_three_phase: CUR_W must be at least 2");
   end

   for (genvar p = 0; p < NUM_LEGS; p++) begin : g_leg
      logic signed [CUR_W-1:0] r_s, m_s;
      logic                    up_c, dn_c;
      logic                    up_q, dn_q;

      assign r_s = $signed(ref_cur[p*CUR_W +: CUR_W]);
      assign m_s = $signed(meas_cur[p*CUR_W +: CUR_W]);

      hcc_band_cmp #(.CUR_W(CUR_W), .HB_W(HB_W)) u_cmp (
         .ref_i      (r_s),
         .meas_i     (m_s),
         .hb_i       (half_band),
         .at_upper_o (up_c),
         .at_lower_o (dn_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
         end else begin
            up_q <= up_c;
            dn_q <= dn_c;
         end
      end

      assign over_band[p]  = up_q;
      assign under_band[p] = dn_q;

      hcc_leg #(.DWELL_CLKS(DWELL_CLKS)) u_leg (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (en),
         .over_i    (up_c),
         .under_i   (dn_c),
         .gate_hi_o (gate_hi[p]),
         .gate_lo_o (gate_lo[p])
      );

      AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         (half_band != '0) |=> !(over_band[p] && under_band[p])); // R2
   end
endmodule

// File: tb/hcc_three_phase_bench.sv
module hcc_three_phase_bench;
   localparam int CLK_P = 10;
   localparam int CUR_W = 12;
   localparam int HB_W  = 8;
   localparam int DWELL = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 en = 1'b0;
   logic [HB_W-1:0]      half_band = '0;
   logic [3*CUR_W-1:0]   ref_cur = '0;
   logic [3*CUR_W-1:0]   meas_cur = '0;
   logic [2:0]           gh, gl, ov, un;

   always #(CLK_P/2) clk = ~clk;

   hcc_three_phase #(.CUR_W(CUR_W), .HB_W(HB_W), .DWELL_CLKS(DWELL)) u_hcc_three_phase (
      .clk(clk), .rst_n(rst_n), .en(en), .half_band(half_band),
      .ref_cur(ref_cur), .meas_cur(meas_cur),
      .gate_hi(gh), .gate_lo(gl), .over_band(ov), .under_band(un)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int ref_v[3];
   int meas_v[3];
   int mst[3];   // 0 off, 1 upper on, 2 lower on
   int gap[3];
   logic [11:0] q_vec[$];
   string       q_tag[$];
   logic [11:0] exp_w;
   string       exp_t;

   // driver: apply one cycle of stimulus and queue the expected result
   task automatic step(input bit e, input int hbv, input string tag);
      logic [2:0] eh, el, eo, eu;
      @(negedge clk);
      en = e;
      half_band = hbv[HB_W-1:0];
      for (int p = 0; p < 3; p++) begin
         int want;
         ref_cur[p*CUR_W +: CUR_W]  = ref_v[p][CUR_W-1:0];
         meas_cur[p*CUR_W +: CUR_W] = meas_v[p][CUR_W-1:0];
         eo[p] = (meas_v[p] >= ref_v[p] + hbv);
         eu[p] = (meas_v[p] <= ref_v[p] - hbv);
         if (!e) begin
            mst[p] = 0;
            gap[p] = DWELL;
         end else begin
            gap[p]++;
            want = eo[p] ? 2 : (eu[p] ? 1 : mst[p]);
            if (want != mst[p] && gap[p] >= DWELL) begin
               mst[p] = want;
               gap[p] = 0;
            end
         end
         eh[p] = (mst[p] == 1);
         el[p] = (mst[p] == 2);
      end
      q_vec.push_back({eh, el, eo, eu});
      q_tag.push_back(tag);
   endtask

   task automatic set_all(input int r, input int m);
      for (int p = 0; p < 3; p++) begin
         ref_v[p] = r;
         meas_v[p] = m;
      end
   endtask

   task automatic steps(input int n, input bit e, input int hbv, input string tag);
      for (int i = 0; i < n; i++) step(e, hbv, tag);
   endtask

   // monitor: compare each produced result against the queue head
   always @(posedge clk) begin
      #1;
      if (q_vec.size() != 0) begin
         exp_w = q_vec.pop_front();
         exp_t = q_tag.pop_front();
         n_chk++;
         if ({gh, gl, ov, un} !== exp_w) begin
            n_bad++;
            $display("FAIL %s: hi=%b lo=%b over=%b under=%b expected hi=%b lo=%b over=%b under=%b",
                     exp_t, gh, gl, ov, un, exp_w[11:9], exp_w[8:6], exp_w[5:3], exp_w[2:0]);
         end
         n_chk++;
         if ((gh & gl) != 3'b000) begin
            n_bad++;
            $display("FAIL R6: hi=%b lo=%b expected no overlap", gh, gl);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++; // R8 reset state
      if ({gh, gl, ov, un} !== 12'h000) begin
         n_bad++;
         $display("FAIL R8: outputs=%h expected 000 in reset", {gh, gl, ov, un});
      end
      rst_n = 1'b1;
      for (int p = 0; p < 3; p++) begin
         mst[p] = 0;
         gap[p] = DWELL;
      end

      set_all(100, 100);  steps(3, 1, 20, "R8");
      set_all(100, 120);  steps(2, 1, 20, "R3");
      set_all(100, 110);  steps(3, 1, 20, "R5");
      set_all(100, 80);   steps(8, 1, 20, "R4");
      set_all(100, 81);   steps(3, 1, 20, "R5");
      set_all(100, 119);  steps(2, 1, 20, "R5");
      set_all(100, 60);   steps(2, 1, 20, "R9");
      set_all(100, 140);  steps(7, 1, 20, "R9");

      set_all(2047, 2047);   steps(2, 1, 255, "R1");
      set_all(-2048, -2048); steps(2, 1, 255, "R1");
      set_all(2000, -2048);  steps(3, 1, 255, "R1");

      set_all(0, 50);  steps(1, 1, 20, "R7");
      set_all(0, 50);  steps(3, 0, 20, "R7");
      set_all(0, -50); steps(3, 1, 20, "R7");

      set_all(0, 0);
      meas_v[0] = 30; meas_v[1] = -30; meas_v[2] = 5;
      steps(8, 1, 20, "R10");

      set_all(10, 10); steps(8, 1, 0, "R11");

      set_all(-200, -200);
      meas_v[0] = -185; meas_v[1] = -215; meas_v[2] = -186;
      steps(4, 1, 15, "R2");
      steps(2, 0, 15, "R2");

      for (int n = 0; n < 600; n++) begin
         for (int p = 0; p < 3; p++) begin
            real ang;
            int  t, tri_v;
            ang = 2.0 * 3.14159265358979 * (real'(n) / 150.0 + real'(p) / 3.0);
            ref_v[p] = int'($rtoi(600.0 * $sin(ang)));
            t = (n + 4 * p) % 24;
            tri_v = (t < 12) ? (-26 + (t * 52) / 12) : (26 - ((t - 12) * 52) / 12);
            meas_v[p] = ref_v[p] + tri_v;
         end
         step(1, 20, "R9");
      end
      steps(3, 0, 20, "R7");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule